// File: doc/BRIEF.md
# Static Branch Predictor with Misprediction Recovery

This fetch-stage unit picks the next fetch address whenever the fetch stage presents a branch. It uses a fixed rule chosen by a two-bit mode input. The rule can be: never taken, taken only for backward branches, or whatever the hint bit in the instruction says. The same branch with the same mode always gets the same prediction. The prediction and next address are combinational, so fetch can use them in the same cycle the branch appears.

Once a branch is accepted, the unit records its address, target and predicted direction, and raises a speculation flag. Write stages use this flag to hold back commits from instructions fetched past the branch. Later in the pipeline the actual outcome arrives on the resolution port. One cycle after resolution, the unit clears the flag and drives the correct continuation address. If the outcome differs from the prediction, it also pulses a squash so that wrong-path work is discarded and fetch restarts at that address. Only one branch may be outstanding; a further branch stalls fetch until the first one resolves.

Top module: `sbp_top`

## Requirements
- R1: After reset, `spec_valid_o`, `squash_o` and `fetch_stall_o` are 0 and `redirect_pc_o` is 0.
- R2: With `mode_i` = 2'b00 an accepted branch is predicted not taken and `next_pc_o` is the branch address + 4.
- R3: With `mode_i` = 2'b01 a branch whose target is strictly below its own address is predicted taken with `next_pc_o` = target; a target equal to or above the address is predicted not taken with `next_pc_o` = address + 4.
- R4: With `mode_i` = 2'b10 the prediction equals `br_hint_i` (1 = taken), and `next_pc_o` follows it.
- R5: With `mode_i` = 2'b11 (reserved) every branch is predicted not taken.
- R6: A branch accepted at a clock edge makes `spec_valid_o` 1 from the next cycle until resolution.
- R7: A branch presented while another is outstanding raises `fetch_stall_o`, gets `pred_taken_o` = 0, and leaves the recorded branch unchanged.
- R8: A resolution whose outcome matches the prediction clears `spec_valid_o` one cycle later with no squash.
- R9: A resolution with outcome taken that was predicted not taken gives a one-cycle `squash_o` pulse one cycle later, with `redirect_pc_o` = recorded target.
- R10: A resolution with outcome not taken that was predicted taken gives the one-cycle `squash_o` pulse, with `redirect_pc_o` = recorded address + 4.
- R11: `res_valid_i` while no branch is outstanding has no effect: no squash, `redirect_pc_o` and `spec_valid_o` unchanged.
- R12: The same branch presented again under the same mode receives the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Prediction rule: 00 never, 01 backward-taken, 10 hint, 11 reserved |
| br_valid_i | input | 1 | A branch is being fetched this cycle |
| br_pc_i | input | AW | Address of the fetched branch |
| br_tgt_i | input | AW | Target address of the fetched branch |
| br_hint_i | input | 1 | Hint bit carried in the instruction |
| pred_taken_o | output | 1 | Branch accepted and predicted taken |
| next_pc_o | output | AW | Predicted next fetch address |
| fetch_stall_o | output | 1 | Branch held back: one is already outstanding |
| res_valid_i | input | 1 | Outcome of the outstanding branch is available |
| res_taken_i | input | 1 | Actual outcome: 1 = taken |
| squash_o | output | 1 | One-cycle pulse: discard wrong-path work |
| redirect_pc_o | output | AW | Correct continuation address of the last resolved branch |
| spec_valid_o | output | 1 | A branch is outstanding; younger writes must wait |

## Verification
The hardest case to reach from the ports is a second branch that arrives while the first one is still outstanding. The bench must show that the second branch stalls and that it does not overwrite the recorded first branch. The stimulus holds a backward-target branch on the fetch inputs for several cycles after a forward branch was accepted. It then resolves the first branch against its prediction, so the redirect address shows which branch was kept. A stray resolution with nothing outstanding is driven right after that, and the bench checks that the redirect address left by the earlier branch is still there.

// File: rtl/sbp_pkg.sv
// Shared types for the static branch predictor.
package sbp_pkg;
    typedef enum logic [1:0] {
        PM_NEVER     = 2'b00,
        PM_BACKWARD  = 2'b01,
        PM_HINT      = 2'b10,
        PM_RESERVED  = 2'b11
    } pred_mode_e;
endpackage

// File: rtl/sbp_rule.sv
// Static direction rule. Purely combinational; picks taken/not-taken from
// the mode, the branch address, its target and the instruction hint bit.
// Assumes addresses are unsigned; an equal target counts as forward.
module sbp_rule #(
    parameter int AW = 32
) (
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] tgt_i,
    input  logic          hint_i,
    output logic          taken_o
);
    import sbp_pkg::*;

    pred_mode_e mode;
    assign mode = pred_mode_e'(mode_i);

    // Select the rule for the current mode.
    always_comb begin
        unique case (mode)
            PM_BACKWARD: taken_o = (tgt_i < pc_i);
            PM_HINT:     taken_o = hint_i;
            default:     taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbp_track.sv
// Outstanding-branch tracker. Records one accepted branch, compares its
// prediction with the resolved outcome and produces a registered squash
// pulse and correct continuation address. Assumes accept_i is never high
// while a branch is already outstanding.
module sbp_track #(
    parameter int AW          = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] tgt_i,
    input  logic          pred_i,
    input  logic          res_valid_i,
    input  logic          res_taken_i,
    output logic          pending_o,
    output logic          squash_o,
    output logic [AW-1:0] redirect_o
);
    localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

    logic          pending_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] tgt_q;
    logic          pred_q;
    logic          squash_q;
    logic [AW-1:0] redirect_q;
    logic          resolve;

    assign resolve = res_valid_i & pending_q;

    // Capture an accepted branch and release it when its outcome arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            pc_q      <= '0;
            tgt_q     <= '0;
            pred_q    <= 1'b0;
        end else if (accept_i) begin
            pending_q <= 1'b1;
            pc_q      <= pc_i;
            tgt_q     <= tgt_i;
            pred_q    <= pred_i;
        end else if (resolve) begin
            pending_q <= 1'b0;
        end
    end

    // Register the recovery outputs for the resolved branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_q   <= 1'b0;
            redirect_q <= '0;
        end else begin
            squash_q <= resolve && (res_taken_i != pred_q);
            if (resolve) begin
                redirect_q <= res_taken_i ? tgt_q : (pc_q + STEP);
            end
        end
    end

    assign pending_o  = pending_q;
    assign squash_o   = squash_q;
    assign redirect_o = redirect_q;
endmodule

// File: rtl/sbp_top.sv
// Static branch predictor with recovery. Predicts each fetched branch in the
// same cycle, tracks one outstanding branch, flags speculation until it
// resolves and redirects fetch on a misprediction. Assumes the resolution
// port only refers to the single outstanding branch.
module sbp_top #(
    parameter int AW          = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          br_valid_i,
    input  logic [AW-1:0] br_pc_i,
    input  logic [AW-1:0] br_tgt_i,
    input  logic          br_hint_i,
    output logic          pred_taken_o,
    output logic [AW-1:0] next_pc_o,
    output logic          fetch_stall_o,
    input  logic          res_valid_i,
    input  logic          res_taken_i,
    output logic          squash_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic          spec_valid_o
);
    localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

    logic rule_taken;
    logic pending;
    logic accept;

    sbp_rule #(.AW(AW)) u_rule (
        .mode_i  (mode_i),
        .pc_i    (br_pc_i),
        .tgt_i   (br_tgt_i),
        .hint_i  (br_hint_i),
        .taken_o (rule_taken)
    );

    // Accept a branch only when none is outstanding.
    always_comb begin
        accept        = br_valid_i & ~pending;
        fetch_stall_o = br_valid_i & pending;
        pred_taken_o  = accept & rule_taken;
        next_pc_o     = pred_taken_o ? br_tgt_i : (br_pc_i + STEP);
    end

    sbp_track #(.AW(AW), .INSTR_BYTES(INSTR_BYTES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .pc_i        (br_pc_i),
        .tgt_i       (br_tgt_i),
        .pred_i      (rule_taken),
        .res_valid_i (res_valid_i),
        .res_taken_i (res_taken_i),
        .pending_o   (pending),
        .squash_o    (squash_o),
        .redirect_o  (redirect_pc_o)
    );

    assign spec_valid_o = pending;
endmodule

// File: rtl/sbp_chk.sv
// Port-level property checker for sbp_top, attached with bind below.
module sbp_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          br_valid_i,
    input logic [AW-1:0] br_pc_i,
    input logic [AW-1:0] br_tgt_i,
    input logic          res_valid_i,
    input logic          pred_taken_o,
    input logic          fetch_stall_o,
    input logic          squash_o,
    input logic          spec_valid_o
);
    a_r2_never_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> !pred_taken_o);

    a_r3_backward_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && br_valid_i && !spec_valid_o && br_tgt_i < br_pc_i) |-> pred_taken_o);

    a_r5_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> !pred_taken_o);

    a_r6_spec_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !fetch_stall_o) |=> spec_valid_o);

    a_r7_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && spec_valid_o) |-> (fetch_stall_o && !pred_taken_o));

    a_r8_spec_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && spec_valid_o) |=> !spec_valid_o);

    a_r9_squash_single: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> !squash_o);

    a_r11_idle_no_squash: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_valid_o |=> !squash_o);
endmodule

bind sbp_top sbp_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .br_valid_i    (br_valid_i),
    .br_pc_i       (br_pc_i),
    .br_tgt_i      (br_tgt_i),
    .res_valid_i   (res_valid_i),
    .pred_taken_o  (pred_taken_o),
    .fetch_stall_o (fetch_stall_o),
    .squash_o      (squash_o),
    .spec_valid_o  (spec_valid_o)
);

// File: tb/sbp_top_tb.sv
`timescale 1ns/1ps
module sbp_top_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          br_valid_i = 1'b0;
    logic [AW-1:0] br_pc_i = '0;
    logic [AW-1:0] br_tgt_i = '0;
    logic          br_hint_i = 1'b0;
    logic          pred_taken_o;
    logic [AW-1:0] next_pc_o;
    logic          fetch_stall_o;
    logic          res_valid_i = 1'b0;
    logic          res_taken_i = 1'b0;
    logic          squash_o;
    logic [AW-1:0] redirect_pc_o;
    logic          spec_valid_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    sbp_top #(.AW(AW), .INSTR_BYTES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .br_valid_i(br_valid_i),
        .br_pc_i(br_pc_i), .br_tgt_i(br_tgt_i), .br_hint_i(br_hint_i),
        .pred_taken_o(pred_taken_o), .next_pc_o(next_pc_o),
        .fetch_stall_o(fetch_stall_o), .res_valid_i(res_valid_i),
        .res_taken_i(res_taken_i), .squash_o(squash_o),
        .redirect_pc_o(redirect_pc_o), .spec_valid_o(spec_valid_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] pc;
        logic [31:0] tgt;
        logic        hint;
        logic        exp_t;
        logic [31:0] exp_next;
        logic        res_t;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 32'h100, 32'h080, 1'b1, 1'b0, 32'h104, 1'b1},
        '{2'b00, 32'h200, 32'h300, 1'b0, 1'b0, 32'h204, 1'b0},
        '{2'b01, 32'h400, 32'h3F0, 1'b0, 1'b1, 32'h3F0, 1'b1},
        '{2'b01, 32'h400, 32'h500, 1'b1, 1'b0, 32'h404, 1'b1},
        '{2'b01, 32'h600, 32'h600, 1'b0, 1'b0, 32'h604, 1'b0},
        '{2'b10, 32'h700, 32'h900, 1'b1, 1'b1, 32'h900, 1'b0},
        '{2'b10, 32'h800, 32'h010, 1'b0, 1'b0, 32'h804, 1'b0},
        '{2'b11, 32'h900, 32'h020, 1'b1, 1'b0, 32'h904, 1'b1},
        '{2'b01, 32'h400, 32'h3F0, 1'b0, 1'b1, 32'h3F0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m, input int idx);
        if (idx == NV - 1) return "R12 repeat";
        case (m)
            2'b00:   return "R2 never";
            2'b01:   return "R3 backward";
            2'b10:   return "R4 hint";
            default: return "R5 reserved";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 spec_valid", 32'(spec_valid_o), 0);
        chk("R1 squash", 32'(squash_o), 0);
        chk("R1 stall", 32'(fetch_stall_o), 0);
        chk("R1 redirect", redirect_pc_o, 0);

        // Table walk: predict, accept, resolve.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            logic exp_sq;
            logic [31:0] exp_rd;
            v = VECS[i];
            t = mode_tag(v.mode, i);
            exp_sq = (v.res_t != v.exp_t);
            exp_rd = v.res_t ? v.tgt : v.pc + 32'd4;
            @(negedge clk);
            mode_i = v.mode; br_pc_i = v.pc; br_tgt_i = v.tgt;
            br_hint_i = v.hint; br_valid_i = 1'b1;
            #1;
            chk({t, " pred"}, 32'(pred_taken_o), 32'(v.exp_t));
            chk({t, " next_pc"}, next_pc_o, v.exp_next);
            chk("R7 no stall when idle", 32'(fetch_stall_o), 0);
            @(negedge clk);
            br_valid_i = 1'b0;
            #1;
            chk("R6 spec_valid raised", 32'(spec_valid_o), 1);
            res_valid_i = 1'b1;
            res_taken_i = v.res_t;
            @(negedge clk);
            res_valid_i = 1'b0;
            #1;
            if (!exp_sq) chk("R8 no squash on match", 32'(squash_o), 0);
            else if (v.res_t) chk("R9 squash", 32'(squash_o), 1);
            else chk("R10 squash", 32'(squash_o), 1);
            chk(v.res_t ? "R9 redirect" : "R10 redirect", redirect_pc_o, exp_rd);
            chk("R8 spec_valid cleared", 32'(spec_valid_o), 0);
        end

        // Second branch while one is outstanding.
        @(negedge clk);
        mode_i = 2'b01; br_pc_i = 32'h1000; br_tgt_i = 32'h2000;
        br_hint_i = 1'b0; br_valid_i = 1'b1;
        #1;
        chk("R3 forward not taken", 32'(pred_taken_o), 0);
        @(negedge clk);
        br_pc_i = 32'h3000; br_tgt_i = 32'h0100;
        #1;
        chk("R7 stall", 32'(fetch_stall_o), 1);
        chk("R7 no prediction", 32'(pred_taken_o), 0);
        @(negedge clk);
        #1;
        chk("R7 stall held", 32'(fetch_stall_o), 1);
        chk("R6 spec_valid held", 32'(spec_valid_o), 1);
        br_valid_i = 1'b0;
        res_valid_i = 1'b1;
        res_taken_i = 1'b1;
        @(negedge clk);
        res_valid_i = 1'b0;
        #1;
        chk("R9 squash after stall", 32'(squash_o), 1);
        chk("R7 recorded branch unchanged", redirect_pc_o, 32'h2000);
        @(negedge clk);
        #1;
        chk("R9 squash single pulse", 32'(squash_o), 0);

        // Resolution with nothing outstanding.
        res_valid_i = 1'b1;
        res_taken_i = 1'b0;
        @(negedge clk);
        res_valid_i = 1'b0;
        #1;
        chk("R11 no squash idle", 32'(squash_o), 0);
        chk("R11 redirect kept", redirect_pc_o, 32'h2000);
        chk("R11 spec_valid low", 32'(spec_valid_o), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule